// File: doc/BRIEF.md
# SDRAM Self-Refresh Entry and Exit Sequencer

This block steers a memory controller into and out of SDRAM self-refresh. Software asks for low power by setting an enable bit while a power-mode select bit is low. The sequencer then lets normal traffic continue until no access is outstanding and the refresh backlog is empty. Only then does it request a precharge of all banks, and once that step reports done it issues the self-refresh command.

While the device is in self-refresh, three events wake it: a pending memory access, the enable bit going low, or the select bit going high. No exit is allowed until a lockout of tCKE+1 cycles after the entry command has passed. A trigger seen during the lockout is remembered, and the exit is issued as soon as the lockout ends. After the exit, two gating outputs hold back non-read/write commands for tSXNR cycles and read/write commands for tSXRD cycles. If the wake-up was caused by an access and low power is still requested, the sequencer drains again and goes back into self-refresh by itself. Encoding commands on the DRAM pins and scheduling refreshes are handled elsewhere.

Top module: `lp_sref_ctrl`

## Requirements
- R1: After reset, pre_all_req, sr_enter_req, sr_exit_req, hold_nonrw and hold_rw are all 0.
- R2: Low power is requested when lp_en=1 and pd_sel=0. pre_all_req first rises two cycles after the first cycle in which the request is present with acc_pend=0 and backlog=0 (one cycle in the drain state, then the precharge state).
- R3: pre_all_req stays high until pre_done is seen high. sr_enter_req is then high for exactly the following cycle, and pre_all_req is low in that cycle.
- R4: sr_enter_req is never asserted unless pre_all_req and pre_done were both high in the cycle before.
- R5: In self-refresh, sr_exit_req is asserted in the same cycle as a trigger (acc_pend=1, lp_en=0 or pd_sel=1) once the lockout has ended. Without a trigger, sr_exit_req stays 0. Entry and exit never occur in the same cycle.
- R6: If sr_enter_req is high in cycle E, sr_exit_req cannot be high before cycle E+t_cke+2.
- R7: A trigger that appears during the lockout and then disappears still produces sr_exit_req, exactly in cycle E+t_cke+2.
- R8: hold_nonrw is high from the cycle after sr_enter_req through the exit cycle X, then for exactly t_sxnr more cycles. It is low from cycle X+t_sxnr+1 on.
- R9: hold_rw behaves the same way, using t_sxrd.
- R10: After an exit caused by an access, if lp_en=1 and pd_sel=0 are still held, the sequencer waits until acc_pend=0 and then requests precharge and re-enters self-refresh.
- R11: If the request is withdrawn while the sequencer is draining, it returns to normal operation, and pre_all_req stays 0 even after the access completes.
- R12: While backlog is nonzero, pre_all_req stays 0. It rises the cycle after backlog reaches zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_en | input | 1 | Low-power enable bit |
| pd_sel | input | 1 | Power-mode select (0 selects self-refresh) |
| acc_pend | input | 1 | A memory access is outstanding |
| backlog | input | BL_W | Refresh commands still owed |
| pre_done | input | 1 | Precharge-all step completed |
| t_cke | input | T_W | Minimum self-refresh residency, minus one |
| t_sxnr | input | T_W | Exit-to-non-read/write delay |
| t_sxrd | input | T_W | Exit-to-read/write delay |
| pre_all_req | output | 1 | Request to close all open rows |
| sr_enter_req | output | 1 | Issue self-refresh command (one cycle) |
| sr_exit_req | output | 1 | Issue self-refresh exit (one cycle) |
| hold_nonrw | output | 1 | Block non-read/write commands |
| hold_rw | output | 1 | Block read/write commands |

## Verification
Entry is exercised with a clean request, with a nonzero backlog and with a request withdrawn mid-drain. Together these show that draining really gates the precharge request and that withdrawal aborts it. Exit is tried with each of the three triggers after the lockout: a trigger that appears inside the lockout and is then removed, and a long idle stretch with no trigger. These separate an unconditional wake-up, an early exit and a forgotten trigger. The post-exit gates are checked with zero and with unequal nonzero delays, so that a swapped or off-by-one counter shows up. An access-driven exit with the request still held shows the automatic re-entry.

// File: rtl/lp_sref_pkg.sv
package lp_sref_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL,
    ST_DRAIN,
    ST_PRECHG,
    ST_ENTER,
    ST_IN_SR,
    ST_EXIT_WAIT,
    ST_POST_EXIT
  } sref_state_e;
endpackage

// File: rtl/lp_sref_cdown.sv
// Loadable down-counter; busy while nonzero.
module lp_sref_cdown #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/lp_sref_fsm.sv
module lp_sref_fsm
  import lp_sref_pkg::*;
#(
  parameter int BL_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lp_en,
  input  logic            pd_sel,
  input  logic            acc_pend,
  input  logic [BL_W-1:0] backlog,
  input  logic            pre_done,
  input  logic            lock_busy,
  input  logic            nr_busy,
  input  logic            rd_busy,
  output logic            pre_all_req,
  output logic            sr_enter_req,
  output logic            sr_exit_req,
  output logic            sr_region
);
  sref_state_e st_q, st_d;
  logic lp_want, wake_trig, drained;

  assign lp_want   = lp_en & ~pd_sel;
  assign wake_trig = acc_pend | ~lp_en | pd_sel;
  assign drained   = ~acc_pend & (backlog == '0);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_NORMAL:    if (lp_want) st_d = ST_DRAIN;
      ST_DRAIN: begin
        if (!lp_want)     st_d = ST_NORMAL;
        else if (drained) st_d = ST_PRECHG;
      end
      ST_PRECHG:    if (pre_done) st_d = ST_ENTER;
      ST_ENTER:     st_d = ST_IN_SR;
      ST_IN_SR: begin
        if (wake_trig) st_d = lock_busy ? ST_EXIT_WAIT : ST_POST_EXIT;
      end
      ST_EXIT_WAIT: if (!lock_busy) st_d = ST_POST_EXIT;
      ST_POST_EXIT: if (!nr_busy && !rd_busy) st_d = ST_NORMAL;
      default:      st_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_NORMAL;
    else        st_q <= st_d;
  end

  assign pre_all_req  = (st_q == ST_PRECHG);
  assign sr_enter_req = (st_q == ST_ENTER);
  assign sr_region    = (st_q == ST_IN_SR) || (st_q == ST_EXIT_WAIT);
  assign sr_exit_req  = ((st_q == ST_IN_SR) && wake_trig && !lock_busy) ||
                        ((st_q == ST_EXIT_WAIT) && !lock_busy);
endmodule

// File: rtl/lp_sref_ctrl.sv
module lp_sref_ctrl #(
  parameter int BL_W = 4,
  parameter int T_W  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lp_en,
  input  logic            pd_sel,
  input  logic            acc_pend,
  input  logic [BL_W-1:0] backlog,
  input  logic            pre_done,
  input  logic [T_W-1:0]  t_cke,
  input  logic [T_W-1:0]  t_sxnr,
  input  logic [T_W-1:0]  t_sxrd,
  output logic            pre_all_req,
  output logic            sr_enter_req,
  output logic            sr_exit_req,
  output logic            hold_nonrw,
  output logic            hold_rw
);
  localparam int LK_W   = T_W + 1;
  localparam int N_HOLD = 2;

  logic lock_busy, sr_region;
  logic [LK_W-1:0] lock_val;
  logic [T_W-1:0]  hold_val  [N_HOLD];
  logic            hold_busy [N_HOLD];

  // residency lockout: tCKE+1 full cycles after the entry command
  assign lock_val = {1'b0, t_cke} + LK_W'(1);

  lp_sref_fsm #(.BL_W(BL_W)) fsm_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .lp_en        (lp_en),
    .pd_sel       (pd_sel),
    .acc_pend     (acc_pend),
    .backlog      (backlog),
    .pre_done     (pre_done),
    .lock_busy    (lock_busy),
    .nr_busy      (hold_busy[0]),
    .rd_busy      (hold_busy[1]),
    .pre_all_req  (pre_all_req),
    .sr_enter_req (sr_enter_req),
    .sr_exit_req  (sr_exit_req),
    .sr_region    (sr_region)
  );

  lp_sref_cdown #(.W(LK_W)) lock_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sr_enter_req),
    .load_val (lock_val),
    .busy     (lock_busy)
  );

  assign hold_val[0] = t_sxnr;
  assign hold_val[1] = t_sxrd;

  for (genvar g = 0; g < N_HOLD; g++) begin : g_hold
    lp_sref_cdown #(.W(T_W)) hold_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sr_exit_req),
      .load_val (hold_val[g]),
      .busy     (hold_busy[g])
    );
  end

  assign hold_nonrw = sr_region | hold_busy[0];
  assign hold_rw    = sr_region | hold_busy[1];
endmodule

// File: rtl/lp_sref_ctrl_chk.sv
module lp_sref_ctrl_chk #(
  parameter int BL_W = 4,
  parameter int T_W  = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lp_en,
  input logic            pd_sel,
  input logic            acc_pend,
  input logic [BL_W-1:0] backlog,
  input logic            pre_done,
  input logic [T_W-1:0]  t_cke,
  input logic            pre_all_req,
  input logic            sr_enter_req,
  input logic            sr_exit_req,
  input logic            hold_nonrw,
  input logic            hold_rw
);
  localparam int CW = T_W + 1;
  logic [CW-1:0] since_q;

  // independent residency window tracker
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_q <= '0;
    else if (sr_enter_req)      since_q <= {1'b0, t_cke} + CW'(1);
    else if (since_q != '0)     since_q <= since_q - CW'(1);
  end

  // R3
  enter_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_enter_req |=> !sr_enter_req);
  // R3
  pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_all_req && !pre_done) |=> pre_all_req);
  // R4
  enter_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_enter_req |-> $past(pre_all_req && pre_done));
  // R2
  pre_needs_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pre_all_req) |-> $past(!acc_pend && backlog == '0 && lp_en && !pd_sel));
  // R5
  no_enter_exit_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sr_enter_req && sr_exit_req));
  // R6
  no_early_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit_req |-> since_q == '0);
  // R8
  exit_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit_req |-> (hold_nonrw && hold_rw));
endmodule

bind lp_sref_ctrl lp_sref_ctrl_chk #(.BL_W(BL_W), .T_W(T_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .lp_en        (lp_en),
  .pd_sel       (pd_sel),
  .acc_pend     (acc_pend),
  .backlog      (backlog),
  .pre_done     (pre_done),
  .t_cke        (t_cke),
  .pre_all_req  (pre_all_req),
  .sr_enter_req (sr_enter_req),
  .sr_exit_req  (sr_exit_req),
  .hold_nonrw   (hold_nonrw),
  .hold_rw      (hold_rw)
);

// File: tb/lp_sref_ctrl_tb_top.sv
module lp_sref_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int BL_W  = 4;
  localparam int T_W   = 4;

  logic clk, rst_n, lp_en, pd_sel, acc_pend, pre_done;
  logic [BL_W-1:0] backlog;
  logic [T_W-1:0]  t_cke, t_sxnr, t_sxrd;
  logic pre_all_req, sr_enter_req, sr_exit_req, hold_nonrw, hold_rw;
  int checks = 0, errors = 0;
  bit done = 0;

  lp_sref_ctrl #(.BL_W(BL_W), .T_W(T_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .lp_en(lp_en), .pd_sel(pd_sel),
    .acc_pend(acc_pend), .backlog(backlog), .pre_done(pre_done),
    .t_cke(t_cke), .t_sxnr(t_sxnr), .t_sxrd(t_sxrd),
    .pre_all_req(pre_all_req), .sr_enter_req(sr_enter_req),
    .sr_exit_req(sr_exit_req), .hold_nonrw(hold_nonrw), .hold_rw(hold_rw)
  );

  initial clk = 0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic settle();
    #1;
  endtask

  // Normal -> drain -> precharge -> enter -> in self-refresh (ends in cycle E+1)
  task automatic go_sr();
    lp_en = 1; pd_sel = 0; acc_pend = 0; backlog = 0; pre_done = 0; settle();
    step(); settle();
    chk("R2 no precharge in drain cycle", pre_all_req, 1'b0);
    step(); settle();
    chk("R2 precharge request raised", pre_all_req, 1'b1);
    pre_done = 1; settle();
    chk("R3 no enter before done sampled", sr_enter_req, 1'b0);
    step(); pre_done = 0; settle();
    chk("R3 enter pulse", sr_enter_req, 1'b1);
    chk("R3 precharge dropped at enter", pre_all_req, 1'b0);
    step(); settle();
    chk("R3 enter single cycle", sr_enter_req, 1'b0);
    chk("R8 nonrw held in self-refresh", hold_nonrw, 1'b1);
    chk("R9 rw held in self-refresh", hold_rw, 1'b1);
  endtask

  task automatic leave_sr();
    acc_pend = 0; pd_sel = 0; lp_en = 0; settle();
    repeat (20) step();
  endtask

  task automatic t_reset();
    chk("R1 pre_all_req reset", pre_all_req, 1'b0);
    chk("R1 sr_enter_req reset", sr_enter_req, 1'b0);
    chk("R1 sr_exit_req reset", sr_exit_req, 1'b0);
    chk("R1 hold_nonrw reset", hold_nonrw, 1'b0);
    chk("R1 hold_rw reset", hold_rw, 1'b0);
  endtask

  // t_cke=3: enter cycle 3, earliest exit cycle 8; trigger pulsed in lockout
  task automatic t_lockout_latch();
    t_cke = 3; t_sxnr = 2; t_sxrd = 4;
    go_sr();                       // now cycle 4
    acc_pend = 1; settle();
    chk("R6 no exit in lockout c4", sr_exit_req, 1'b0);
    step(); acc_pend = 0; settle(); // cycle 5, trigger gone
    chk("R6 no exit in lockout c5", sr_exit_req, 1'b0);
    step(); settle();
    chk("R6 no exit in lockout c6", sr_exit_req, 1'b0);
    step(); settle();
    chk("R6 no exit in lockout c7", sr_exit_req, 1'b0);
    step(); settle();               // cycle 8
    chk("R7 latched trigger exits at E+t_cke+2", sr_exit_req, 1'b1);
    chk("R8 nonrw held in exit cycle", hold_nonrw, 1'b1);
    step(); lp_en = 0; settle();    // cycle 9
    chk("R7 exit single cycle", sr_exit_req, 1'b0);
    chk("R8 nonrw held X+1", hold_nonrw, 1'b1);
    chk("R9 rw held X+1", hold_rw, 1'b1);
    step(); settle();               // 10
    chk("R8 nonrw held X+2", hold_nonrw, 1'b1);
    step(); settle();               // 11
    chk("R8 nonrw released X+3", hold_nonrw, 1'b0);
    chk("R9 rw held X+3", hold_rw, 1'b1);
    step(); settle();               // 12
    chk("R9 rw held X+4", hold_rw, 1'b1);
    step(); settle();               // 13
    chk("R9 rw released X+5", hold_rw, 1'b0);
    leave_sr();
  endtask

  // t_cke=0: enter cycle 3, earliest exit cycle 5; enable cleared
  task automatic t_exit_enable();
    t_cke = 0; t_sxnr = 0; t_sxrd = 0;
    go_sr();                       // cycle 4
    chk("R5 no exit without trigger", sr_exit_req, 1'b0);
    step(); lp_en = 0; settle();   // cycle 5
    chk("R5 exit on enable cleared", sr_exit_req, 1'b1);
    step(); settle();
    chk("R8 zero delay nonrw released", hold_nonrw, 1'b0);
    chk("R9 zero delay rw released", hold_rw, 1'b0);
    leave_sr();
  endtask

  task automatic t_exit_select();
    t_cke = 0; t_sxnr = 0; t_sxrd = 0;
    go_sr();
    for (int i = 0; i < 6; i++) begin
      step(); settle();
      chk("R5 idle self-refresh no exit", sr_exit_req, 1'b0);
    end
    pd_sel = 1; settle();
    chk("R5 exit on select set", sr_exit_req, 1'b1);
    leave_sr();
  endtask

  task automatic t_auto_reenter();
    t_cke = 0; t_sxnr = 1; t_sxrd = 1;
    go_sr();                       // 4
    step(); acc_pend = 1; settle(); // 5
    chk("R5 exit on access", sr_exit_req, 1'b1);
    step(); settle();              // 6 post-exit
    step(); settle();              // 7
    step(); settle();              // 8 normal
    step(); settle();              // 9 drain
    chk("R10 wait for access to finish", pre_all_req, 1'b0);
    step(); acc_pend = 0; settle(); // 10
    chk("R10 still draining", pre_all_req, 1'b0);
    step(); settle();              // 11
    chk("R10 re-entry precharge", pre_all_req, 1'b1);
    pre_done = 1; step(); pre_done = 0; settle();
    chk("R10 re-entry enter pulse", sr_enter_req, 1'b1);
    leave_sr();
  endtask

  task automatic t_backlog();
    t_cke = 0; t_sxnr = 0; t_sxrd = 0;
    lp_en = 1; pd_sel = 0; acc_pend = 0; backlog = 2; pre_done = 0; settle();
    for (int i = 0; i < 4; i++) begin
      step(); settle();
      chk("R12 backlog blocks precharge", pre_all_req, 1'b0);
    end
    backlog = 0; settle();
    step(); settle();
    chk("R12 precharge after backlog clears", pre_all_req, 1'b1);
    for (int i = 0; i < 3; i++) begin
      step(); settle();
      chk("R3 precharge held until done", pre_all_req, 1'b1);
    end
    pre_done = 1; step(); pre_done = 0; settle();
    chk("R3 enter after delayed done", sr_enter_req, 1'b1);
    leave_sr();
  endtask

  task automatic t_withdraw();
    lp_en = 1; pd_sel = 0; acc_pend = 1; backlog = 0; pre_done = 0; settle();
    step(); step(); lp_en = 0; settle();
    step(); acc_pend = 0; settle();
    for (int i = 0; i < 4; i++) begin
      step(); settle();
      chk("R11 withdrawn request no precharge", pre_all_req, 1'b0);
    end
  endtask

  initial begin
    rst_n = 0; lp_en = 0; pd_sel = 0; acc_pend = 0; backlog = 0; pre_done = 0;
    t_cke = 0; t_sxnr = 0; t_sxrd = 0;
    repeat (3) @(posedge clk);
    #1; settle();
    t_reset();
    rst_n = 1;
    step(); settle();
    t_lockout_latch();
    t_exit_enable();
    t_exit_select();
    t_auto_reenter();
    t_backlog();
    t_withdraw();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule